// File: doc/BRIEF.md
# LED Matrix Row-Scan Timing Generator

This block produces every timing signal needed to multiplex an eight-character 5x7 LED dot-matrix display. It advances on a master clock tick that comes either from a free-running internal divider or from an outside clock pin. When the internal source is selected, that source is driven onto the shared clock pin, so a second module can take its timing from it. Modules that share this clock and a common reset therefore scan and blink in lock-step.

Each master tick advances a chain of three counters. The first is a 32-step slot counter. Each full pass of the slots makes one row period, and the slots also serve as sub-slots for brightness duty-cycle comparison. The second is a 7-step row counter whose wrap ends a frame. The third is a 128-step frame counter. The lowest bit of the frame counter picks which of the two banks of seven row lines is driven. The top bit of the frame counter is the blink phase.

Slot 0 of every row is a dead slot. All row enables are off during it, and a column-load strobe tells the column logic to present the next row's data before that row is lit.

Top module: `scan_timer`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, slot, row_idx, row_group, row_en, blink_phase, slot_tick, col_load and frame_strobe are all zero.
- R2: With clk_sel=1 a master tick occurs every INT_DIV system clocks. The first tick comes INT_DIV clocks after reset release. mclk_out is high for the first INT_DIV/2 clocks of each tick period. mclk_oe equals clk_sel.
- R3: With clk_sel=0, each rising edge on ext_clk produces exactly one master tick. The counters show its effect three system clock edges after the first edge that samples ext_clk high. The internal divider then causes no ticks.
- R4: With clk_sel=1, activity on ext_clk has no effect on any output.
- R5: slot counts master ticks from 0 to 31 and then wraps to 0.
- R6: row_idx advances by one each time slot wraps from 31 to 0. It counts 0 to 6 and then wraps to 0.
- R7: row_group equals bit 0 of the frame count. row_en is one-hot outside slot 0, with bit row_group*7+row_idx set.
- R8: row_en is all zero whenever slot is 0. col_load is high for exactly the one cycle in which slot has just become 0.
- R9: frame_strobe is high for exactly the one cycle in which row_idx and slot have both just wrapped to 0. Each such wrap advances the frame count by one, modulo 128.
- R10: blink_phase equals bit 6 of the frame count, so it is high for frames 64 to 127.
- R11: slot_tick is high for exactly the one cycle after each master tick has updated the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the only clock in the design |
| rst_n | input | 1 | Active-low synchronous reset, shared between cascaded modules |
| clk_sel | input | 1 | 1 = internal divider is the master source, 0 = take ext_clk |
| ext_clk | input | 1 | Master clock from another module (asynchronous) |
| mclk_out | output | 1 | Internal master clock square wave for the shared pin |
| mclk_oe | output | 1 | Drive enable for the shared clock pin |
| slot | output | 5 | Sub-slot within the current row (0..31) |
| slot_tick | output | 1 | One-cycle pulse after each master tick |
| row_idx | output | 3 | Row within the current bank (0..6) |
| row_group | output | 1 | Bank of seven row lines in use |
| row_en | output | 14 | One-hot row drive over both banks |
| col_load | output | 1 | Pulse: present next row's column data |
| frame_strobe | output | 1 | Pulse at the start of each frame |
| blink_phase | output | 1 | Slow blink phase (frame counter MSB) |

## Verification
The hardest state to reach from the ports is the blink phase turning on. It needs 64 complete frames, which is 14,336 master ticks. The bench overrides the internal divider to 4 and runs the internal mode long enough to cross that boundary, while checking every output on every cycle against a model built on its own edge count. During that run it toggles ext_clk at random to show that the unselected input is ignored. A separate external-mode run uses random high and low widths, pins the three-edge latency down with one directed edge, and then walks through several row and bank wraps.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int unsigned DEF_SLOTS   = 32;
    localparam int unsigned DEF_ROWS    = 7;
    localparam int unsigned DEF_FRAMES  = 128;
    localparam int unsigned DEF_INT_DIV = 16;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } clk_src_e;
endpackage

// File: rtl/scan_clk_src.sv
module scan_clk_src
    import scan_pkg::*;
#(
    parameter int unsigned INT_DIV = DEF_INT_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sel,
    input  logic ext_clk,
    output logic mclk_out,
    output logic tick
);
    localparam int unsigned DW   = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
    localparam int unsigned HALF = INT_DIV / 2;

    typedef struct packed {
        logic [DW-1:0] div;
        logic [2:0]    sync;
    } src_state_t;

    src_state_t st_d, st_q;
    logic int_tick, ext_rise;

    always_comb begin
        st_d      = st_q;
        int_tick  = (st_q.div == DW'(INT_DIV - 1));
        st_d.div  = int_tick ? '0 : st_q.div + DW'(1);
        st_d.sync = {st_q.sync[1:0], ext_clk};
        ext_rise  = st_q.sync[1] & ~st_q.sync[2];
        tick      = (clk_src_e'(clk_sel) == SRC_INT) ? int_tick : ext_rise;
        mclk_out  = (st_q.div < DW'(HALF));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/scan_chain.sv
module scan_chain
    import scan_pkg::*;
#(
    parameter int unsigned SLOTS  = DEF_SLOTS,
    parameter int unsigned ROWS   = DEF_ROWS,
    parameter int unsigned FRAMES = DEF_FRAMES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    output logic [$clog2(SLOTS)-1:0]  slot,
    output logic [$clog2(ROWS)-1:0]   row,
    output logic                      frame_lsb,
    output logic                      frame_msb,
    output logic                      slot_tick
);
    localparam int unsigned SW = $clog2(SLOTS);
    localparam int unsigned RW = $clog2(ROWS);
    localparam int unsigned FW = $clog2(FRAMES);

    typedef struct packed {
        logic [SW-1:0] slot;
        logic [RW-1:0] row;
        logic [FW-1:0] frame;
        logic          stick;
    } chain_state_t;

    chain_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.stick = tick;
        if (tick) begin
            if (st_q.slot == SW'(SLOTS - 1)) begin
                st_d.slot = '0;
                if (st_q.row == RW'(ROWS - 1)) begin
                    st_d.row   = '0;
                    st_d.frame = st_q.frame + FW'(1);
                end else begin
                    st_d.row = st_q.row + RW'(1);
                end
            end else begin
                st_d.slot = st_q.slot + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot      = st_q.slot;
    assign row       = st_q.row;
    assign frame_lsb = st_q.frame[0];
    assign frame_msb = st_q.frame[FW-1];
    assign slot_tick = st_q.stick;
endmodule

// File: rtl/scan_row_drv.sv
module scan_row_drv
    import scan_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned ROWS  = DEF_ROWS
) (
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic [$clog2(ROWS)-1:0]  row,
    input  logic                     group,
    input  logic                     slot_tick,
    output logic [2*ROWS-1:0]        row_en,
    output logic                     col_load,
    output logic                     frame_strobe
);
    localparam int unsigned RW = $clog2(ROWS);

    logic live;

    always_comb begin
        live         = (slot != '0);
        col_load     = slot_tick && (slot == '0);
        frame_strobe = col_load && (row == '0);
    end

    for (genvar g = 0; g < 2; g++) begin : g_bank
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign row_en[g*ROWS + r] = live && (group == (g == 1)) && (row == RW'(r));
        end
    end
endmodule

// File: rtl/scan_timer.sv
module scan_timer
    import scan_pkg::*;
#(
    parameter int unsigned INT_DIV = DEF_INT_DIV,
    parameter int unsigned SLOTS   = DEF_SLOTS,
    parameter int unsigned ROWS    = DEF_ROWS,
    parameter int unsigned FRAMES  = DEF_FRAMES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_sel,
    input  logic                     ext_clk,
    output logic                     mclk_out,
    output logic                     mclk_oe,
    output logic [$clog2(SLOTS)-1:0] slot,
    output logic                     slot_tick,
    output logic [$clog2(ROWS)-1:0]  row_idx,
    output logic                     row_group,
    output logic [2*ROWS-1:0]        row_en,
    output logic                     col_load,
    output logic                     frame_strobe,
    output logic                     blink_phase
);
    logic tick;

    assign mclk_oe = clk_sel;

    scan_clk_src #(.INT_DIV(INT_DIV)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .ext_clk  (ext_clk),
        .mclk_out (mclk_out),
        .tick     (tick)
    );

    scan_chain #(.SLOTS(SLOTS), .ROWS(ROWS), .FRAMES(FRAMES)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .slot      (slot),
        .row       (row_idx),
        .frame_lsb (row_group),
        .frame_msb (blink_phase),
        .slot_tick (slot_tick)
    );

    scan_row_drv #(.SLOTS(SLOTS), .ROWS(ROWS)) u_drv (
        .slot         (slot),
        .row          (row_idx),
        .group        (row_group),
        .slot_tick    (slot_tick),
        .row_en       (row_en),
        .col_load     (col_load),
        .frame_strobe (frame_strobe)
    );
endmodule

// File: rtl/scan_timer_chk.sv
module scan_timer_chk #(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned ROWS  = 7
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [$clog2(SLOTS)-1:0] slot,
    input logic                     slot_tick,
    input logic [$clog2(ROWS)-1:0]  row_idx,
    input logic [2*ROWS-1:0]        row_en,
    input logic                     frame_strobe,
    input logic                     blink_phase
);
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en)); // R7
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_tick |-> $stable(slot)); // R11
    AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_idx <= ($clog2(ROWS))'(ROWS - 1)); // R6
    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> (row_idx == '0 && slot == '0 && slot_tick)); // R9
    AST_DEAD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> (row_en == '0)); // R8
    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> $stable(blink_phase)); // R10
endmodule

bind scan_timer scan_timer_chk #(.SLOTS(SLOTS), .ROWS(ROWS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot         (slot),
    .slot_tick    (slot_tick),
    .row_idx      (row_idx),
    .row_en       (row_en),
    .frame_strobe (frame_strobe),
    .blink_phase  (blink_phase)
);

// File: tb/scan_timer_bench.sv
module scan_timer_bench;
    localparam int unsigned D = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_sel = 1'b1;
    logic        ext_clk = 1'b0;
    logic        mclk_out, mclk_oe, slot_tick, row_group, col_load, frame_strobe, blink_phase;
    logic [4:0]  slot;
    logic [2:0]  row_idx;
    logic [13:0] row_en;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned k      = 0;
    bit          done   = 0;

    scan_timer #(.INT_DIV(D)) u_scan_timer (
        .clk, .rst_n, .clk_sel, .ext_clk, .mclk_out, .mclk_oe, .slot, .slot_tick,
        .row_idx, .row_group, .row_en, .col_load, .frame_strobe, .blink_phase
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_row_en(int unsigned n);
        int unsigned s = n % 32;
        int unsigned r = (n / 32) % 7;
        int unsigned g = ((n / 224) % 128) % 2;
        return (s == 0) ? 0 : (1 << (g * 7 + r));
    endfunction

    task automatic check_state(int unsigned n, bit stick, string tag);
        int unsigned s  = n % 32;
        int unsigned r  = (n / 32) % 7;
        int unsigned fr = (n / 224) % 128;
        chk("R5",  {tag, " slot"},         slot,         s);
        chk("R6",  {tag, " row_idx"},      row_idx,      r);
        chk("R7",  {tag, " row_group"},    row_group,    fr % 2);
        chk("R7",  {tag, " row_en"},       row_en,       exp_row_en(n));
        chk("R8",  {tag, " col_load"},     col_load,     (stick && s == 0) ? 1 : 0);
        chk("R9",  {tag, " frame_strobe"}, frame_strobe, (stick && s == 0 && r == 0) ? 1 : 0);
        chk("R10", {tag, " blink_phase"},  blink_phase,  (fr >= 64) ? 1 : 0);
        chk("R11", {tag, " slot_tick"},    slot_tick,    stick ? 1 : 0);
    endtask

    task automatic do_reset(bit sel);
        @(negedge clk);
        rst_n   = 1'b0;
        clk_sel = sel;
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        check_state(0, 0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_state(0, 0, "R1 after release");
    endtask

    initial begin
        #2_500_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned rises;
        void'($urandom(32'd2718));

        // Internal mode, long enough to see the blink phase rise (R2, R4, R10)
        do_reset(1'b1);
        for (int c = 0; c < 60000; c++) begin
            @(negedge clk);
            check_state(k / D, (k > 0) && (k % D == 0), "R4 int");
            chk("R2", "mclk_out", mclk_out, ((k % D) < D / 2) ? 1 : 0);
            chk("R2", "mclk_oe",  mclk_oe,  1);
            ext_clk = 1'($urandom);
        end

        // External mode: directed latency (R3)
        do_reset(1'b0);
        chk("R2", "mclk_oe ext", mclk_oe, 0);
        ext_clk = 1'b1;
        @(negedge clk);
        chk("R3", "slot after 1 edge", slot, 0);
        @(negedge clk);
        chk("R3", "slot after 2 edges", slot, 0);
        @(negedge clk);
        chk("R3", "slot after 3 edges", slot, 1);
        chk("R3", "slot_tick after 3 edges", slot_tick, 1);
        ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        rises = 1;
        check_state(rises, 0, "R3 first");

        // External mode: random widths across row and bank wraps
        for (int e = 0; e < 600; e++) begin
            int unsigned hi = 2 + ($urandom % 4);
            int unsigned lo = 2 + ($urandom % 4);
            ext_clk = 1'b1;
            repeat (hi) @(negedge clk);
            ext_clk = 1'b0;
            repeat (lo) @(negedge clk);
            rises++;
            check_state(rises, 0, "R3 ext");
            chk("R2", "mclk_oe ext", mclk_oe, 0);
        end

        // Reset after activity clears everything (R1)
        do_reset(1'b1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule